// File: doc/BRIEF.md
# Optical-Black Averaging Clamp

This block derives the black level of an image sensor row from its digitised samples. A trigger pulse that marks the optically shielded pixels starts a fixed-length sampling window, timed in clock cycles from the moment the trigger is accepted. Eight consecutive samples taken inside that window are summed, and the sum is shifted right by three to form their mean. That mean becomes the held clamp reference, and every later valid sample has it subtracted on the way out.

The trigger passes through a two-stage synchroniser. It is only accepted after it has stayed high for a minimum number of sampled clocks, so short glitches cannot disturb the reference. Because of the synchroniser, the window can land one clock earlier or later, depending on where the raw trigger edge falls relative to the clock. While a window is in progress, further triggers are ignored.

Top module: `ob_black_clamp`

## Requirements
- R1: During and after reset, `clamp_lvl` is 0, `lvl_upd` is 0 and `corr_vld` is 0; with the reset level of 0, a valid sample comes out of `corr_out` unchanged.
- R2: A trigger is accepted only when `ob_trig` is seen high at three consecutive rising clock edges. A shorter pulse causes no update and leaves `clamp_lvl` unchanged.
- R3: Let `ob_trig` first be high at clock edge E0 and be accepted. The window then samples `smp_in` at edges E9 through E16 (synchroniser plus qualification, then clocks five to twelve after acceptance). Samples at E8 and E17 are excluded.
- R4: The new level is the floor of the sum of the eight window samples divided by eight. Eight full-scale samples (1023) give 1023, with no overflow.
- R5: The new level appears on `clamp_lvl` in the cycle after the eighth window sample (after edge E16). `lvl_upd` is high for exactly that one cycle.
- R6: A trigger accepted while a window is in progress is ignored. It neither restarts nor extends the window.
- R7: One clock after a valid sample, `corr_out` equals `smp_in` minus `clamp_lvl`, floored at 0, and `corr_vld` is 1. When `smp_vld` is 0, `corr_vld` drops to 0 and `corr_out` holds its last value.
- R8: `clamp_lvl` changes only in a cycle where `lvl_upd` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ob_trig | input | 1 | Asynchronous optical-black trigger pulse |
| smp_in | input | 10 | Converted pixel sample |
| smp_vld | input | 1 | Sample valid flag |
| clamp_lvl | output | 10 | Held black reference |
| lvl_upd | output | 1 | One-cycle strobe when the reference is refreshed |
| corr_out | output | 10 | Sample minus reference, floored at zero |
| corr_vld | output | 1 | Valid flag for `corr_out` |

## Verification
The hardest case to reach from the ports is a second trigger that qualifies while the window is open. To produce it, the bench releases the first pulse after three clocks, then raises the trigger again for five clocks so that its acceptance falls inside the window. The bench then checks that the resulting level is the mean of the first window alone and that no second strobe follows. Window edges are checked by driving an out-of-range value of 1023 on the samples just before and just after the window, so that any off-by-one sampling changes the computed mean.

// File: rtl/ob_clamp_pkg.sv
// Package: shared defaults and helper for the optical-black clamp.
// Assumes: sample width and window length are small; window length is a power of two.
package ob_clamp_pkg;
    localparam int SMP_W_DFLT    = 10;
    localparam int MIN_HIGH_DFLT = 3;
    localparam int OPEN_AT_DFLT  = 5;
    localparam int WIN_LEN_DFLT  = 8;
    localparam int SYNC_N_DFLT   = 2;
endpackage

// File: rtl/ob_trig_qual.sv
// Module: ob_trig_qual
// Synchronises the raw trigger and emits a one-cycle accept pulse once the
// synchronised trigger has stayed high for MIN_HIGH consecutive cycles.
// Assumes: trig_raw is asynchronous; reset is synchronous, active low.
module ob_trig_qual #(
    parameter int SYNC_N   = ob_clamp_pkg::SYNC_N_DFLT,
    parameter int MIN_HIGH = ob_clamp_pkg::MIN_HIGH_DFLT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig_raw,
    output logic accept
);
    localparam int RUN_W = $clog2(MIN_HIGH + 1);

    logic [SYNC_N-1:0] sync_q;
    logic [RUN_W-1:0]  run_q;
    logic              trig_s;

    // Synchroniser chain, one flop per stage.
    generate
        for (genvar g = 0; g < SYNC_N; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= trig_raw;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    assign trig_s = sync_q[SYNC_N-1];

    // Run-length counter of synchronised high cycles, saturating past the limit.
    always_ff @(posedge clk) begin
        if (!rst_n)                          run_q <= '0;
        else if (!trig_s)                    run_q <= '0;
        else if (run_q != RUN_W'(MIN_HIGH))  run_q <= run_q + 1'b1;
    end

    // Accept exactly once, on the MIN_HIGH-th high cycle.
    assign accept = trig_s && (run_q == RUN_W'(MIN_HIGH - 1));

    // R2: acceptance needs the trigger high in the previous cycle too.
    p_min_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> $past(trig_s));
    // R2: a held trigger is accepted only once.
    p_one_shot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
endmodule

// File: rtl/ob_window_seq.sv
// Module: ob_window_seq
// Counts clocks after an accepted trigger and marks the sampling window,
// which spans counts OPEN_AT to OPEN_AT+WIN_LEN-1. Accepts are ignored while busy.
// Assumes: accept is a one-cycle pulse from ob_trig_qual.
module ob_window_seq #(
    parameter int OPEN_AT = ob_clamp_pkg::OPEN_AT_DFLT,
    parameter int WIN_LEN = ob_clamp_pkg::WIN_LEN_DFLT
) (
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    output logic win_en,
    output logic win_first,
    output logic win_last
);
    localparam int CLOSE_AT = OPEN_AT + WIN_LEN - 1;
    localparam int CNT_W    = $clog2(CLOSE_AT + 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy;

    assign busy = (cnt_q != '0);

    // Cycle counter: starts at 1 on accept, runs to CLOSE_AT, then idles at 0.
    always_ff @(posedge clk) begin
        if (!rst_n)                          cnt_q <= '0;
        else if (busy) begin
            if (cnt_q == CNT_W'(CLOSE_AT))   cnt_q <= '0;
            else                             cnt_q <= cnt_q + 1'b1;
        end else if (accept)                 cnt_q <= CNT_W'(1);
    end

    // Window decode from the counter.
    assign win_en    = (cnt_q >= CNT_W'(OPEN_AT)) && (cnt_q <= CNT_W'(CLOSE_AT));
    assign win_first = (cnt_q == CNT_W'(OPEN_AT));
    assign win_last  = (cnt_q == CNT_W'(CLOSE_AT));

    // R6: once running, the counter only advances, whatever accept does.
    p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !win_last) |=> (cnt_q == $past(cnt_q) + 1'b1));
    // R3: the window closes right after its last slot.
    p_close_r3: assert property (@(posedge clk) disable iff (!rst_n)
        win_last |=> !win_en);
endmodule

// File: rtl/ob_level_avg.sv
// Module: ob_level_avg
// Sums the samples of the window and, after the last one, stores the sum
// divided by WIN_LEN (truncating shift) as the clamp level, with a one-cycle strobe.
// Assumes: WIN_LEN is a power of two; win_first/win_last lie inside win_en.
module ob_level_avg #(
    parameter int SMP_W   = ob_clamp_pkg::SMP_W_DFLT,
    parameter int WIN_LEN = ob_clamp_pkg::WIN_LEN_DFLT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             win_en,
    input  logic             win_first,
    input  logic             win_last,
    input  logic [SMP_W-1:0] smp,
    output logic [SMP_W-1:0] level,
    output logic             upd
);
    localparam int SHIFT = $clog2(WIN_LEN);
    localparam int ACC_W = SMP_W + SHIFT;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] sum_now;

    // Running sum including the current sample; the first slot restarts it.
    assign sum_now = (win_first ? '0 : acc_q) + {{SHIFT{1'b0}}, smp};

    // Accumulator register across the window.
    always_ff @(posedge clk) begin
        if (!rst_n)      acc_q <= '0;
        else if (win_en) acc_q <= sum_now;
    end

    // Held level and update strobe, loaded after the last window sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            level <= '0;
            upd   <= 1'b0;
        end else begin
            upd <= win_last;
            if (win_last) level <= sum_now[ACC_W-1:SHIFT];
        end
    end

    // R5: the strobe lasts one cycle.
    p_upd_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> !upd);
    // R8: the level moves only together with the strobe.
    p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |-> $stable(level));
    // R5: a strobe follows the last window slot.
    p_upd_after_last_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |-> $past(win_last));
endmodule

// File: rtl/ob_sub_sat.sv
// Module: ob_sub_sat
// Registers each valid sample minus the clamp level, floored at zero.
// Output holds while no valid sample arrives.
// Assumes: level is already in the sample's scale.
module ob_sub_sat #(
    parameter int SMP_W = ob_clamp_pkg::SMP_W_DFLT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp,
    input  logic             vld,
    input  logic [SMP_W-1:0] level,
    output logic [SMP_W-1:0] corr,
    output logic             corr_vld
);
    logic [SMP_W:0]   diff;
    logic [SMP_W-1:0] floored;

    // Extended subtraction; the top bit flags a negative result.
    assign diff    = {1'b0, smp} - {1'b0, level};
    assign floored = diff[SMP_W] ? '0 : diff[SMP_W-1:0];

    // Output register with one-cycle latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            corr     <= '0;
            corr_vld <= 1'b0;
        end else begin
            corr_vld <= vld;
            if (vld) corr <= floored;
        end
    end

    // R7: a valid result never exceeds the sample it came from.
    p_no_exceed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        corr_vld |-> (corr <= $past(smp)));
    // R7: the output holds when no sample was valid.
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !corr_vld |-> $stable(corr));
endmodule

// File: rtl/ob_black_clamp.sv
// Module: ob_black_clamp (top)
// Optical-black clamp: trigger qualification, window timing, averaging and
// subtraction of the black reference from the sample stream.
// Assumes: ob_trig is asynchronous; all else is synchronous to clk.
module ob_black_clamp #(
    parameter int SMP_W    = ob_clamp_pkg::SMP_W_DFLT,
    parameter int SYNC_N   = ob_clamp_pkg::SYNC_N_DFLT,
    parameter int MIN_HIGH = ob_clamp_pkg::MIN_HIGH_DFLT,
    parameter int OPEN_AT  = ob_clamp_pkg::OPEN_AT_DFLT,
    parameter int WIN_LEN  = ob_clamp_pkg::WIN_LEN_DFLT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ob_trig,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             smp_vld,
    output logic [SMP_W-1:0] clamp_lvl,
    output logic             lvl_upd,
    output logic [SMP_W-1:0] corr_out,
    output logic             corr_vld
);
    logic accept;
    logic win_en;
    logic win_first;
    logic win_last;

    ob_trig_qual #(.SYNC_N(SYNC_N), .MIN_HIGH(MIN_HIGH)) u_qual (
        .clk(clk), .rst_n(rst_n), .trig_raw(ob_trig), .accept(accept)
    );

    ob_window_seq #(.OPEN_AT(OPEN_AT), .WIN_LEN(WIN_LEN)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .win_en(win_en), .win_first(win_first), .win_last(win_last)
    );

    ob_level_avg #(.SMP_W(SMP_W), .WIN_LEN(WIN_LEN)) u_avg (
        .clk(clk), .rst_n(rst_n), .win_en(win_en), .win_first(win_first),
        .win_last(win_last), .smp(smp_in), .level(clamp_lvl), .upd(lvl_upd)
    );

    ob_sub_sat #(.SMP_W(SMP_W)) u_sub (
        .clk(clk), .rst_n(rst_n), .smp(smp_in), .vld(smp_vld),
        .level(clamp_lvl), .corr(corr_out), .corr_vld(corr_vld)
    );

    // R1: nothing is strobed or valid in the cycle after reset.
    p_reset_quiet_r1: assert property (@(posedge clk)
        !$past(rst_n) |-> (!lvl_upd && !corr_vld && clamp_lvl == '0));
endmodule

// File: tb/sim_ob_black_clamp.sv
module sim_ob_black_clamp;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       ob_trig;
    logic [9:0] smp_in;
    logic       smp_vld;
    logic [9:0] clamp_lvl;
    logic       lvl_upd;
    logic [9:0] corr_out;
    logic       corr_vld;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  ended  = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    ob_black_clamp u0 (
        .clk(clk), .rst_n(rst_n), .ob_trig(ob_trig), .smp_in(smp_in),
        .smp_vld(smp_vld), .clamp_lvl(clamp_lvl), .lvl_upd(lvl_upd),
        .corr_out(corr_out), .corr_vld(corr_vld)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    // R1: reset state and pass-through with a zero level.
    task automatic t_reset();
        rst_n = 1'b0; ob_trig = 1'b0; smp_in = 10'd0; smp_vld = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "clamp_lvl in reset", int'(clamp_lvl), 0);
        check("R1", "lvl_upd in reset", int'(lvl_upd), 0);
        check("R1", "corr_vld in reset", int'(corr_vld), 0);
        rst_n = 1'b1;
        smp_in = 10'd321; smp_vld = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R1", "pass-through corr_out", int'(corr_out), 321);
        check("R1", "pass-through corr_vld", int'(corr_vld), 1);
        smp_vld = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    // Drives one trigger/window sequence (R2..R6, R8). Called at a negedge.
    // Index i is the clock edge Ei at which the driven values are sampled.
    task automatic run_window(input int width, input bit retrig, input int b0, input int b1,
                              input int b2, input int b3, input int b4, input int b5,
                              input int b6, input int b7, input bit exp_upd, input string req);
        int blk [8];
        int sum;
        int prev;
        int stray;
        int exp_lvl;
        blk[0] = b0; blk[1] = b1; blk[2] = b2; blk[3] = b3;
        blk[4] = b4; blk[5] = b5; blk[6] = b6; blk[7] = b7;
        sum = 0;
        foreach (blk[k]) sum += blk[k];
        prev  = int'(clamp_lvl);
        stray = 0;
        exp_lvl = exp_upd ? (sum / 8) : prev;
        smp_vld = 1'b1;
        for (int i = 0; i <= 40; i++) begin
            ob_trig = (i < width) || (retrig && i >= 5 && i < 10);
            smp_in  = (i >= 9 && i <= 16) ? 10'(blk[i-9]) : 10'd1023;
            @(posedge clk); @(negedge clk);
            if (i == 16) begin
                check(req, "lvl_upd after last sample", int'(lvl_upd), int'(exp_upd));
                check(req, "clamp_lvl after window", int'(clamp_lvl), exp_lvl);
            end else if (lvl_upd) begin
                stray++;
            end
        end
        check(req, "no stray lvl_upd", stray, 0);
        check("R8", "clamp_lvl held after window", int'(clamp_lvl), exp_lvl);
        ob_trig = 1'b0; smp_vld = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    // R7: subtraction, flooring and hold with the current level.
    task automatic t_correct();
        int lvl;
        lvl = int'(clamp_lvl);
        smp_vld = 1'b1; smp_in = 10'd200;
        @(posedge clk); @(negedge clk);
        check("R7", "corr above level", int'(corr_out), 200 - lvl);
        check("R7", "corr_vld", int'(corr_vld), 1);
        smp_in = 10'd30;
        @(posedge clk); @(negedge clk);
        check("R7", "corr floored below level", int'(corr_out), 0);
        smp_in = 10'(lvl);
        @(posedge clk); @(negedge clk);
        check("R7", "corr at level", int'(corr_out), 0);
        smp_in = 10'd900;
        @(posedge clk); @(negedge clk);
        check("R7", "corr high sample", int'(corr_out), 900 - lvl);
        smp_vld = 1'b0; smp_in = 10'd500;
        @(posedge clk); @(negedge clk);
        check("R7", "corr_vld low", int'(corr_vld), 0);
        check("R7", "corr held", int'(corr_out), 900 - lvl);
    endtask

    initial begin
        t_reset();
        // R3/R4/R5: ramp, mean 828/8 = 103; 1023 on E8 and E17 would skew it
        run_window(3, 1'b0, 100, 101, 102, 103, 104, 105, 106, 107, 1'b1, "R3");
        // R4: truncation, 83/8 = 10
        run_window(4, 1'b0, 10, 10, 10, 10, 10, 10, 10, 13, 1'b1, "R4");
        // R4: full scale, 8184/8 = 1023
        run_window(3, 1'b0, 1023, 1023, 1023, 1023, 1023, 1023, 1023, 1023, 1'b1, "R4");
        // R6: retrigger during window ignored, level 64
        run_window(3, 1'b1, 64, 64, 64, 64, 64, 64, 64, 64, 1'b1, "R6");
        // R2: two-clock pulse rejected, level stays 64
        run_window(2, 1'b0, 5, 5, 5, 5, 5, 5, 5, 5, 1'b0, "R2");
        check("R2", "level kept after short pulse", int'(clamp_lvl), 64);
        t_correct();
        finish_run();
    end

    initial begin
        repeat (5000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end
endmodule